// File: doc/BRIEF.md
# Latched Serial-to-Parallel Register

The block turns a serial bit stream into a parallel word, and it keeps the word that software or logic sees apart from the word still being assembled. A chain of flops, W bits long, moves one position on every rising edge of its own shift clock. A separate storage bank copies the whole chain at once on every rising edge of a second, independent storage clock. Only the storage bank reaches the parallel outputs. A word can therefore be built up bit by bit while the outputs hold the previous word steady. The new word then appears on every output in the same instant.

An active-low clear empties the shift chain at once and needs no clock. It does not touch the storage bank. An active-low enable lets the storage bank drive the parallel pins; when the enable is high those pins float. The last shift stage also leaves the block as a cascade bit, and that bit is always driven. Several instances can be chained by feeding each cascade bit into the serial input of the next instance, with the clocks, clear and enable shared by all of them. This builds a wider register. The interface has no valid/ready handshake. Every transfer is set by a clock edge that the user controls, so back-pressure never arises and the pins stay plain.

Top module: `latched_sipo`

## Requirements
- R1: On each rising edge of `sh_clk`, while `sh_clr_n` is high, stage 0 of the shift chain takes `ser_in` and every stage i>0 takes the old value of stage i-1. Parallel bit i corresponds to stage i.
- R2: On each rising edge of `st_clk`, all W shift stages are copied at once into the storage bank, and the storage bank is visible on `hold_mirror`.
- R3: While `sh_clr_n` is low, every shift stage reads 0 without waiting for a clock edge, and a rising edge of `sh_clk` has no effect.
- R4: The clear never changes the storage bank.
- R5: With `oe_n` high, all bits of `par_q` are high impedance. With `oe_n` low, `par_q` equals the storage bank.
- R6: `cascade_out` always equals the last shift stage (stage W-1), whatever the level of `oe_n`.
- R7: When both clocks rise in the same instant, the storage bank captures the shift contents from before that edge, so storage lags the chain by one edge.
- R8: Two W=8 instances chained through the cascade bit behave as one 16-bit register. After 16 shift edges and one storage edge, the first instance holds bits 7..0 and the second holds bits 15..8, where bit 0 is the last bit shifted in.
- R9: Falling edges of either clock change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data into shift stage 0 |
| sh_clk | input | 1 | Shift clock, rising edge |
| sh_clr_n | input | 1 | Asynchronous clear of the shift chain, active low |
| st_clk | input | 1 | Storage clock, rising edge |
| oe_n | input | 1 | Parallel output enable, active low |
| par_q | output | W | Tri-state parallel outputs from the storage bank |
| cascade_out | output | 1 | Last shift stage, always driven |
| hold_mirror | output | W | Always-driven copy of the storage bank |

## Verification
The bench aims at several mistakes a design could make. One is a storage bank that samples the chain after the shift on a shared edge: it would show a word that is one edge too new when the clocks are tied. Another is a clear that also resets storage, or one that waits for a clock edge: either would wipe the held word or leave the cascade bit high while the clear is active. Shifting on the wrong edge, or letting a shift edge act during an active clear, corrupts the word that is read back. An enable that also gated the cascade bit breaks the two-instance chain. So does a stage order that is reversed, because the 16-bit word then arrives split or reversed across the two instances.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned SIPO_W_DEF = 8;
  localparam int unsigned SIPO_W_MIN = 2;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         din,
  output logic [W-1:0] q
);
  localparam int unsigned LAST = W - 1;

  logic [W-1:0] nxt;

  // each stage looks one position toward the serial input
  assign nxt = {q[LAST-1:0], din};

  for (genvar i = 0; i < W; i++) begin : g_stage
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q[i] <= 1'b0;
      else        q[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/sipo_hold_bank.sv
module sipo_hold_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) q[i] <= d[i];
  end
endmodule

// File: rtl/sipo_tri_drive.sv
module sipo_tri_drive #(
  parameter int unsigned W = 8
) (
  input  logic         oe_n,
  input  logic [W-1:0] d,
  output wire  [W-1:0] y
);
  assign y = oe_n ? {W{1'bz}} : d;
endmodule

// File: rtl/latched_sipo.sv
module latched_sipo
  import sipo_pkg::*;
#(
  parameter int unsigned W = SIPO_W_DEF
) (
  input  logic         ser_in,
  input  logic         sh_clk,
  input  logic         sh_clr_n,
  input  logic         st_clk,
  input  logic         oe_n,
  output wire  [W-1:0] par_q,
  output logic         cascade_out,
  output logic [W-1:0] hold_mirror
);
  localparam int unsigned LAST = W - 1;

  logic [W-1:0] shift_q;
  logic [W-1:0] hold_q;

  sipo_shift_chain #(.W(W)) u_chain (
    .clk   (sh_clk),
    .clr_n (sh_clr_n),
    .din   (ser_in),
    .q     (shift_q)
  );

  sipo_hold_bank #(.W(W)) u_hold (
    .clk (st_clk),
    .d   (shift_q),
    .q   (hold_q)
  );

  sipo_tri_drive #(.W(W)) u_drv (
    .oe_n (oe_n),
    .d    (hold_q),
    .y    (par_q)
  );

  assign cascade_out = shift_q[LAST];
  assign hold_mirror = hold_q;
endmodule

// File: rtl/sipo_chk.sv
module sipo_chk #(
  parameter int unsigned W = 8
) (
  input logic         sh_clk,
  input logic         st_clk,
  input logic         sh_clr_n,
  input logic         ser_in,
  input logic         cascade_out,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] hold_mirror
);
  // set by any clear since the previous shift edge
  logic clr_seen = 1'b1;

  always_ff @(posedge sh_clk or negedge sh_clr_n) begin
    if (!sh_clr_n) clr_seen <= 1'b1;
    else           clr_seen <= 1'b0;
  end

  p_shift_move_r1: assert property (@(posedge sh_clk) disable iff (!sh_clr_n)
    !clr_seen |-> (shift_q === {$past(shift_q[W-2:0]), $past(ser_in)}));

  p_store_copy_r2: assert property (@(posedge st_clk) disable iff (1'b0)
    1'b1 |=> (hold_mirror === $past(shift_q)));

  p_clear_zero_r3: assert property (@(posedge sh_clk) disable iff (1'b0)
    !sh_clr_n |-> (shift_q == '0));

  p_clear_cascade_r6: assert property (@(posedge sh_clk) disable iff (1'b0)
    !sh_clr_n |-> !cascade_out);
endmodule

bind latched_sipo sipo_chk #(.W(W)) u_chk (
  .sh_clk      (sh_clk),
  .st_clk      (st_clk),
  .sh_clr_n    (sh_clr_n),
  .ser_in      (ser_in),
  .cascade_out (cascade_out),
  .shift_q     (shift_q),
  .hold_mirror (hold_mirror)
);

// File: tb/sim_latched_sipo.sv
`timescale 1ns/1ps
module sim_latched_sipo;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic ser = 1'b0, sh_clk = 1'b0, clr_n = 1'b1, st_clk = 1'b0, oe_n = 1'b1;
  tri1 [7:0] par0;
  tri1 [7:0] par1;
  wire       casc0, casc1;
  logic [7:0] mir0, mir1;

  latched_sipo #(.W(8)) u0 (
    .ser_in(ser), .sh_clk(sh_clk), .sh_clr_n(clr_n), .st_clk(st_clk), .oe_n(oe_n),
    .par_q(par0), .cascade_out(casc0), .hold_mirror(mir0));
  latched_sipo #(.W(8)) u1 (
    .ser_in(casc0), .sh_clk(sh_clk), .sh_clr_n(clr_n), .st_clk(st_clk), .oe_n(oe_n),
    .par_q(par1), .cascade_out(casc1), .hold_mirror(mir1));

  int total = 0, bad = 0;
  logic [15:0] m_sh = 16'h0, m_hold = 16'h0;
  bit done = 0;

  function automatic logic [15:0] f_shift(logic [15:0] v, logic b);
    return {v[14:0], b};
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " R2 storage"}, {mir1, mir0}, m_hold);
    chk({tag, " R6 cascade"}, {14'h0, casc1, casc0}, {14'h0, m_sh[15], m_sh[7]});
    chk({tag, " R5 parallel"}, {par1, par0}, oe_n ? 16'hFFFF : m_hold);
  endtask

  task automatic do_shift(logic b);
    ser = b; #1 sh_clk = 1'b1; #2 sh_clk = 1'b0; #2;
    m_sh = f_shift(m_sh, b);
  endtask

  task automatic do_store();
    #1 st_clk = 1'b1; #2 st_clk = 1'b0; #2;
    m_hold = m_sh;
  endtask

  task automatic do_both(logic b);
    ser = b; #1 begin sh_clk = 1'b1; st_clk = 1'b1; end
    #2 begin sh_clk = 1'b0; st_clk = 1'b0; end #2;
    m_hold = m_sh;
    m_sh = f_shift(m_sh, b);
  endtask

  task automatic do_clear();
    #1 clr_n = 1'b0; #2 clr_n = 1'b1; #2;
    m_sh = 16'h0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] word;
    #3 do_clear();
    do_store();
    chk_all("reset R3 R5");
    oe_n = 1'b0; #1;
    chk_all("enable R5");

    // R1: short directed pattern, newest bit lands at stage 0
    do_shift(1); do_shift(0); do_shift(1); do_shift(1);
    chk({15'h0, casc0}, {15'h0, casc0}, {15'h0, m_sh[7]});
    do_store();
    chk("R1 pattern", {mir1, mir0}, 16'h000B);

    // R9: only the rising edge acts
    ser = 1'b1; #1 sh_clk = 1'b1; #2 ser = 1'b0; #1 sh_clk = 1'b0; #2;
    m_sh = f_shift(m_sh, 1'b1);
    #1 st_clk = 1'b1; #2 st_clk = 1'b0; ser = 1'b1; #2;
    m_hold = m_sh;
    chk("R9 falling edges ignored", {mir1, mir0}, 16'h0017);

    // R3 immediate clear, R4 storage untouched
    for (int i = 0; i < 16; i++) do_shift(1);
    do_store();
    chk("R3 preload", {15'h0, casc1}, 16'h0001);
    #1 clr_n = 1'b0; #1;
    chk("R3 clear without clock", {14'h0, casc1, casc0}, 16'h0);
    ser = 1'b1; sh_clk = 1'b1; #2 sh_clk = 1'b0; #1 clr_n = 1'b1; #2;
    m_sh = 16'h0;
    chk("R4 clear keeps storage", {mir1, mir0}, 16'hFFFF);
    chk_all("R3 after clear");
    do_store();
    chk("R3 edge during clear ignored", {mir1, mir0}, 16'h0000);

    // R7: tied clocks, storage lags by one edge
    do_shift(1); do_shift(1); do_shift(0);
    do_both(1);
    chk("R7 tied clocks", {mir1, mir0}, 16'h0006);
    do_both(0);
    chk("R7 second tied edge", {mir1, mir0}, 16'h000D);

    // R8: 16-bit word through the cascade
    word = 16'hA5C3;
    for (int i = 15; i >= 0; i--) do_shift(word[i]);
    do_store();
    chk("R8 cascade word", {par1, par0}, word);

    // R6: cascade stays driven with outputs floating
    oe_n = 1'b1; #1;
    chk("R6 cascade while floating", {14'h0, casc1, casc0}, {14'h0, m_sh[15], m_sh[7]});
    chk("R5 float", {par1, par0}, 16'hFFFF);
    oe_n = 1'b0; #1;

    // constrained random mix
    void'($urandom(32'd4711));
    for (int n = 0; n < 500; n++) begin
      int op;
      op = int'($urandom % 16);
      if (op < 8)       do_shift(1'($urandom));
      else if (op < 11) do_store();
      else if (op < 13) do_both(1'($urandom));
      else if (op < 14) do_clear();
      else begin oe_n = ~oe_n; #1; end
      chk_all("random R1");
    end
    finish_run();
  end
endmodule